// File: doc/BRIEF.md
# DS3 Transmit Payload Input Interface

This block takes outbound DS3 payload from terminal equipment and turns it into a serial payload stream, with a flag that marks each overhead slot so that a downstream inserter can fill it. It keeps the DS3 frame position itself. A frame is 4760 bit slots, made of 56 blocks of 85 slots. The first slot of each block is overhead and the remaining 84 slots carry payload. The block runs on a single bit-rate clock.

A static mode input selects how the equipment delivers data. In serial mode (mode low), the equipment drives one payload bit per clock. The block raises a warning one slot before every overhead slot, ignores the serial input during that slot, and pulses an end-of-frame flag on the last slot of each frame. In nibble mode (mode high), the block raises a one-cycle nibble strobe every four payload slots. That gives 1176 strobes per frame, with none during overhead. The block captures the 4-bit input on the strobed clock edge and shifts it out MSB first. A nibble end-of-frame flag covers the four slots of the last nibble.

Top module: `ds3_tx_payload_in`

## Requirements
- R1: While reset is asserted, `out_data`, `out_oh`, `oh_warn`, `frame_end`, `nib_strobe` and `nib_frame_end` are all 0. The first clock slot after reset release is slot 0 of a frame, which is an overhead slot.
- R2: Slot numbers run from 0 to 4759 within a frame. A slot s is overhead when s mod 85 equals 0. For each slot, `out_oh` and `out_data` show that slot one clock later. For an overhead slot, `out_oh` is 1 and `out_data` is 0; for every other slot, `out_oh` is 0.
- R3: In serial mode, `oh_warn` is 1 exactly in the slots where s mod 85 equals 84, which is the slot just before each overhead slot. The value of `ser_in` during an overhead slot has no effect on the output.
- R4: In serial mode, for each payload slot, `out_data` one clock later equals the `ser_in` value sampled in that slot.
- R5: In serial mode, `frame_end` is 1 only in slot 4759, once per frame.
- R6: In nibble mode, `nib_strobe` is 1 exactly in payload slots where (s mod 85) minus 1 is a multiple of 4. That gives 1176 strobes per frame and none in an overhead slot.
- R7: In nibble mode, `nib_in` is captured on the clock edge that ends a strobed slot. Its bits 3, 2, 1 and 0 appear on `out_data` for that slot and the next three slots, in that order.
- R8: In nibble mode, `nib_frame_end` is 1 in slots 4756 to 4759, which are the four slots of the last nibble of the frame, and in no other slot.
- R9: In nibble mode, `oh_warn` and `frame_end` stay 0. In serial mode, `nib_strobe` and `nib_frame_end` stay 0.
- R10: In serial mode, `nib_in` has no effect on any output. In nibble mode, `ser_in` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| nib_mode | input | 1 | Static mode select: 0 serial, 1 nibble |
| ser_in | input | 1 | Serial payload bit from equipment |
| nib_in | input | 4 | Nibble payload from equipment, bit 3 sent first |
| oh_warn | output | 1 | Next slot is overhead (serial mode) |
| frame_end | output | 1 | Current slot is last of frame (serial mode) |
| nib_strobe | output | 1 | Nibble is taken on this cycle's closing edge |
| nib_frame_end | output | 1 | Last nibble of frame is in progress |
| out_data | output | 1 | Payload stream, 0 in overhead slots |
| out_oh | output | 1 | Marks an overhead slot on the stream |

## Verification
The assertions check, on every cycle, a fixed set of properties:
- the stream carries a 0 whenever the overhead flag is set;
- two cycles after each warning the overhead flag is set;
- serial bits pass through with a single cycle of delay;
- strobes never fall in consecutive cycles;
- each frame pulse lasts one cycle and the nibble frame flag begins on a strobe;
- the indicators that belong to the other mode stay idle.

The bench's scenarios are what show the properties that span many cycles:
- the exact slot positions across two full frames in each mode;
- per-frame totals of 4704 payload slots and 1176 strobes;
- MSB-first ordering of random nibbles;
- that a 1 driven on the serial input during overhead slots, and activity on the input of the unused mode, never reach the stream.

// File: rtl/ds3_tx_payload_in.sv
module ds3_tx_payload_in #(
  parameter int BLK_BITS     = 85,
  parameter int BLKS_PER_SUB = 8,
  parameter int SUBFRAMES    = 7,
  parameter int NIB_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nib_mode,
  input  logic             ser_in,
  input  logic [NIB_W-1:0] nib_in,
  output logic             oh_warn,
  output logic             frame_end,
  output logic             nib_strobe,
  output logic             nib_frame_end,
  output logic             out_data,
  output logic             out_oh
);
  localparam int FRAME_BLKS = BLKS_PER_SUB * SUBFRAMES;
  localparam int POS_W      = $clog2(BLK_BITS);
  localparam int BLK_W      = $clog2(FRAME_BLKS);
  localparam int PH_W       = $clog2(NIB_W);

  logic [POS_W-1:0] pos;
  logic [BLK_W-1:0] blk;
  logic [PH_W-1:0]  ph;
  logic [NIB_W-2:0] sh;

  wire slot_oh  = (pos == '0);
  wire last_pos = (pos == POS_W'(BLK_BITS - 1));
  wire last_blk = (blk == BLK_W'(FRAME_BLKS - 1));
  wire nib_go   = !slot_oh && (ph == '0);

  assign oh_warn       = !nib_mode && last_pos;
  assign frame_end     = !nib_mode && last_pos && last_blk;
  assign nib_strobe    = nib_mode && nib_go;
  assign nib_frame_end = nib_mode && last_blk && (pos > POS_W'(BLK_BITS - 1 - NIB_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      blk      <= '0;
      ph       <= '0;
      sh       <= '0;
      out_data <= 1'b0;
      out_oh   <= 1'b0;
    end else begin
      pos    <= last_pos ? '0 : pos + POS_W'(1);
      if (last_pos) blk <= last_blk ? '0 : blk + BLK_W'(1);
      ph     <= slot_oh ? '0 : ph + PH_W'(1);
      out_oh <= slot_oh;
      if (slot_oh)        out_data <= 1'b0;
      else if (!nib_mode) out_data <= ser_in;
      else if (nib_go)    {out_data, sh} <= nib_in;
      else                {out_data, sh} <= {sh, 1'b0};
    end
  end

  AST_OH_ZERO:       assert property (@(posedge clk) disable iff (!rst_n) out_oh |-> !out_data); // R2
  AST_WARN_LEADS:    assert property (@(posedge clk) disable iff (!rst_n) oh_warn |=> ##1 out_oh); // R3
  AST_SER_PASS:      assert property (@(posedge clk) disable iff (!rst_n) (!nib_mode && !slot_oh) |=> (out_data == $past(ser_in))); // R4
  AST_FE_PULSE:      assert property (@(posedge clk) disable iff (!rst_n) frame_end |=> !frame_end); // R5
  AST_STROBE_GAP:    assert property (@(posedge clk) disable iff (!rst_n) nib_strobe |=> !nib_strobe); // R6
  AST_NFE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $rose(nib_frame_end) |-> nib_strobe); // R8
  AST_NIB_QUIET:     assert property (@(posedge clk) disable iff (!rst_n) nib_mode |-> (!oh_warn && !frame_end)); // R9
  AST_SER_QUIET:     assert property (@(posedge clk) disable iff (!rst_n) !nib_mode |-> (!nib_strobe && !nib_frame_end)); // R9
endmodule

// File: tb/ds3_tx_payload_in_tb.sv
module ds3_tx_payload_in_tb;
  localparam int FRAME = 4760;
  localparam int BLK   = 85;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nib_mode = 1'b0;
  logic ser_in = 1'b0;
  logic [3:0] nib_in = 4'h0;
  logic oh_warn, frame_end, nib_strobe, nib_frame_end, out_data, out_oh;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ds3_tx_payload_in u_dut (
    .clk(clk), .rst_n(rst_n), .nib_mode(nib_mode), .ser_in(ser_in), .nib_in(nib_in),
    .oh_warn(oh_warn), .frame_end(frame_end), .nib_strobe(nib_strobe),
    .nib_frame_end(nib_frame_end), .out_data(out_data), .out_oh(out_oh)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_mode(input bit mode, input int frames);
    int  k;
    bit  e_data, e_oh, oh, strb;
    bit [3:0] nv;
    int  idx, pay_cnt, stb_cnt, fe_cnt, nfe_cnt, m;
    rst_n = 1'b0;
    nib_mode = mode;
    repeat (3) begin
      @(negedge clk);
      chk(out_data == 0 && out_oh == 0, "R1 registered outputs in reset", {out_data, out_oh}, 0);
      chk({oh_warn, frame_end, nib_strobe, nib_frame_end} == 0, "R1 indicators in reset",
          {oh_warn, frame_end, nib_strobe, nib_frame_end}, 0);
    end
    rst_n = 1'b1;
    k = 0; e_data = 0; e_oh = 0; nv = 0; idx = 0;
    pay_cnt = 0; stb_cnt = 0; fe_cnt = 0; nfe_cnt = 0;
    for (int c = 0; c < frames * FRAME + 1; c++) begin
      m = k % BLK;
      oh = (m == 0);
      strb = mode && !oh && ((m - 1) % 4 == 0);
      chk(out_oh == e_oh, c == 1 ? "R1 first slot overhead" : "R2 out_oh", out_oh, e_oh);
      chk(out_data == e_data, mode ? "R7/R10 nibble data" : "R2/R4/R10 serial data", out_data, e_data);
      chk(oh_warn == (!mode && m == BLK - 1), mode ? "R9 oh_warn" : "R3 oh_warn", oh_warn, !mode && m == BLK - 1);
      chk(frame_end == (!mode && k == FRAME - 1), mode ? "R9 frame_end" : "R5 frame_end", frame_end, !mode && k == FRAME - 1);
      chk(nib_strobe == strb, mode ? "R6 nib_strobe" : "R9 nib_strobe", nib_strobe, strb);
      chk(nib_frame_end == (mode && k >= FRAME - 4), mode ? "R8 nib_frame_end" : "R9 nib_frame_end",
          nib_frame_end, mode && k >= FRAME - 4);
      if (c == frames * FRAME) break;
      ser_in = oh ? 1'b1 : 1'($urandom);
      nib_in = 4'($urandom);
      if (!oh) pay_cnt++;
      if (nib_strobe) stb_cnt++;
      if (frame_end) fe_cnt++;
      if (nib_frame_end) nfe_cnt++;
      e_oh = oh;
      if (oh) e_data = 1'b0;
      else if (!mode) e_data = ser_in;
      else if (strb) begin nv = nib_in; e_data = nv[3]; idx = 2; end
      else begin e_data = nv[idx]; idx--; end
      if (k == FRAME - 1) begin
        chk(pay_cnt == 4704, "R2 payload slots per frame", pay_cnt, 4704);
        chk(stb_cnt == (mode ? 1176 : 0), "R6 strobes per frame", stb_cnt, mode ? 1176 : 0);
        chk(fe_cnt == (mode ? 0 : 1), "R5 frame pulses per frame", fe_cnt, mode ? 0 : 1);
        chk(nfe_cnt == (mode ? 4 : 0), "R8 nibble frame cycles", nfe_cnt, mode ? 4 : 0);
        pay_cnt = 0; stb_cnt = 0; fe_cnt = 0; nfe_cnt = 0;
      end
      k = (k + 1) % FRAME;
      @(negedge clk);
    end
  endtask

  initial begin
    run_mode(1'b0, 2);
    run_mode(1'b1, 2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule